// File: doc/BRIEF.md
# Status-Line Interrupt Controller

This block watches twelve status lines from a configurable device and drives a single interrupt toward a host processor. Every register uses the same bit map. Bit 11 is power-good and bits 10 to 8 are the done, status and configuration pin levels. Bits 7 to 4 are the partial-reconfiguration done, error and ready flags and the via-PCIe configuration done flag. Bits 3 to 0 are CRC error, initialization done, configuration done and status-ok.

The host chooses which lines take part, whether each one is sensed by level or by edge, which polarity counts as active, and which active lines may reach the interrupt output. It reads back the raw condition, the masked condition and the synchronized line levels. It clears latched edge events by writing ones to a write-only end-of-interrupt register. The lines are asynchronous to the clock, so they pass through a two-flop synchronizer before any other logic sees them.

Writes take effect at the clock edge on which `wr_i` is high. Reads are combinational from `addr_i`. Register offsets: enable 0x830, mask 0x834, type 0x838, polarity 0x83C, masked status 0x840, raw status 0x844, end-of-interrupt 0x84C, line levels 0x850.

Top module: `mon_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: The line-level register at 0x850 returns, in bits [11:0], the value of `line_i` two clock edges after it was applied, and returns zero in bits [31:12].
- R3: A line whose enable bit (0x830) is 0 never shows in raw status, in masked status or on `irq_o`.
- R4: With its type bit (0x838) at 0, an enabled line is level sensed and shows in raw status (0x844) while its synchronized level equals its polarity bit (0x83C): 1 means active high, 0 means active low.
- R5: With its type bit at 1, an enabled line latches a pending event in the cycle its synchronized level goes from inactive to active under the current polarity. The event stays in raw status after the line returns inactive. A polarity change alone does not create an event.
- R6: Writing 1 to a bit of the end-of-interrupt register (0x84C) clears that line's pending edge event, and bits written 0 leave their events alone. A level-sensed line that is still active stays in raw status through such a write. The register reads zero.
- R7: Masked status (0x840) equals raw status with every line whose mask bit (0x834) is 1 removed. Masking does not change raw status.
- R8: `irq_o` is high one clock edge after masked status is nonzero, and low one edge after it becomes zero.
- R9: Enable, mask, type and polarity read back the value last written to bits [11:0], with zero above. Writes to the status, line-level and unmapped offsets change nothing, and unmapped offsets read zero.
- R10: Clearing a line's enable bit or type bit discards its pending edge event, and setting the bit again does not bring the event back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 12 | Asynchronous device status lines |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt to the host |

## Verification
The bench targets the falling-edge case, where a polarity write must not invent an event. A design that compares raw levels instead of active levels would latch a pending event there, or miss the real falling transition. The bench issues end-of-interrupt writes against both level-sensed and edge-sensed lines, and writes that contain zero bits. A design that cleared level lines, or cleared all lines, would show the wrong raw status in the next cycle. It toggles enable and type while an event is pending, which exposes a design that keeps stale events. A long pseudo-random phase compares every read and `irq_o` with a cycle-exact model, which catches an extra or missing stage in the synchronizer or the interrupt register.

// File: rtl/mon_irq_pkg.sv
package mon_irq_pkg;
  localparam int unsigned LINE_W = 12;

  localparam int unsigned OFS_EN   = 32'h830;
  localparam int unsigned OFS_MSK  = 32'h834;
  localparam int unsigned OFS_TYP  = 32'h838;
  localparam int unsigned OFS_POL  = 32'h83C;
  localparam int unsigned OFS_MST  = 32'h840;
  localparam int unsigned OFS_RAW  = 32'h844;
  localparam int unsigned OFS_EOI  = 32'h84C;
  localparam int unsigned OFS_LVL  = 32'h850;

  typedef logic [LINE_W-1:0] line_vec_t;

  typedef struct packed {
    line_vec_t en;
    line_vec_t msk;
    line_vec_t typ;  // 1 = edge
    line_vec_t pol;  // 1 = active high
  } irq_cfg_t;
endpackage

// File: rtl/mon_irq_sync.sv
module mon_irq_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mon_irq_regs.sv
module mon_irq_regs
  import mon_irq_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output irq_cfg_t      cfg_o,
  output line_vec_t     eoi_o
);
  irq_cfg_t  cfg_q;
  line_vec_t wr_val;
  logic      unused_wdata;

  assign wr_val       = wdata_i[LINE_W-1:0];
  assign unused_wdata = ^wdata_i[DW-1:LINE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      case (32'(addr_i))
        OFS_EN:  cfg_q.en  <= wr_val;
        OFS_MSK: cfg_q.msk <= wr_val;
        OFS_TYP: cfg_q.typ <= wr_val;
        OFS_POL: cfg_q.pol <= wr_val;
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
  assign eoi_o = (wr_i && 32'(addr_i) == OFS_EOI) ? wr_val : '0;
endmodule

// File: rtl/mon_irq_event.sv
module mon_irq_event
  import mon_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_vec_t lvl_i,
  input  irq_cfg_t  cfg_i,
  input  line_vec_t eoi_i,
  output line_vec_t raw_o,
  output line_vec_t masked_o,
  output line_vec_t pend_o,
  output line_vec_t edge_o
);
  line_vec_t lvl_d_q, pend_q;
  line_vec_t act_now, act_prev, keep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= '0;
    else         lvl_d_q <= lvl_i;
  end

  // active = level matches polarity, judged with the current polarity on both samples
  assign act_now  = ~(lvl_i   ^ cfg_i.pol);
  assign act_prev = ~(lvl_d_q ^ cfg_i.pol);
  assign edge_o   = act_now & ~act_prev & cfg_i.en & cfg_i.typ;
  assign keep     = pend_q & ~eoi_i & cfg_i.en & cfg_i.typ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= keep | edge_o;  // new edge wins over a same-cycle clear
  end

  assign pend_o   = pend_q;
  assign raw_o    = cfg_i.en & ((cfg_i.typ & pend_q) | (~cfg_i.typ & act_now));
  assign masked_o = raw_o & ~cfg_i.msk;
endmodule

// File: rtl/mon_irq_ctrl.sv
module mon_irq_ctrl
  import mon_irq_pkg::*;
#(
  parameter int unsigned AW          = 12,
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  irq_cfg_t  cfg;
  line_vec_t eoi_clr, lvl_s, raw, masked, pend, edge_evt;
  line_vec_t rd_sel;
  logic      irq_q;

  mon_irq_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(line_i), .q_o(lvl_s)
  );

  mon_irq_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .cfg_o(cfg), .eoi_o(eoi_clr)
  );

  mon_irq_event u_evt (
    .clk_i, .rst_ni, .lvl_i(lvl_s), .cfg_i(cfg), .eoi_i(eoi_clr),
    .raw_o(raw), .masked_o(masked), .pend_o(pend), .edge_o(edge_evt)
  );

  always_comb begin
    case (32'(addr_i))
      OFS_EN:  rd_sel = cfg.en;
      OFS_MSK: rd_sel = cfg.msk;
      OFS_TYP: rd_sel = cfg.typ;
      OFS_POL: rd_sel = cfg.pol;
      OFS_MST: rd_sel = masked;
      OFS_RAW: rd_sel = raw;
      OFS_LVL: rd_sel = lvl_s;
      default: rd_sel = '0;
    endcase
  end

  assign rdata_o = DW'(rd_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |masked;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mon_irq_chk.sv
module mon_irq_chk
  import mon_irq_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input irq_cfg_t      cfg,
  input line_vec_t     eoi_clr,
  input line_vec_t     raw,
  input line_vec_t     masked,
  input line_vec_t     pend,
  input line_vec_t     edge_evt
);
  p_lvl_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) == OFS_LVL) |-> (rdata_o[DW-1:LINE_W] == '0));

  p_disabled_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw & ~cfg.en) == '0);

  p_pend_needs_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & ~$past(pend)) & ~$past(edge_evt)) == '0);

  p_eoi_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & $past(eoi_clr & ~edge_evt)) == '0);

  p_mask_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked & cfg.msk) == '0);

  p_irq_lag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(masked != '0));
endmodule

bind mon_irq_ctrl mon_irq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .cfg(cfg), .eoi_clr(eoi_clr), .raw(raw), .masked(masked),
  .pend(pend), .edge_evt(edge_evt)
);

// File: tb/test_mon_irq_ctrl.sv
module test_mon_irq_ctrl;
  localparam int EN = 'h830, MSK = 'h834, TYP = 'h838, POL = 'h83C;
  localparam int MST = 'h840, RAW = 'h844, EOI = 'h84C, LVL = 'h850;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] line = '0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mon_irq_ctrl i_mon_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  logic [11:0] m_en = '0, m_msk = '0, m_typ = '0, m_pol = '0, m_pend = '0;
  logic [11:0] h0 = '0, h1 = '0, h2 = '0;
  bit m_irq = 0;

  function automatic logic [11:0] m_raw();
    logic [11:0] act;
    act = ~(h1 ^ m_pol);
    return m_en & ((m_typ & m_pend) | (~m_typ & act));
  endfunction

  function automatic logic [31:0] m_read(int a);
    case (a)
      EN:  return {20'h0, m_en};
      MSK: return {20'h0, m_msk};
      TYP: return {20'h0, m_typ};
      POL: return {20'h0, m_pol};
      MST: return {20'h0, m_raw() & ~m_msk};
      RAW: return {20'h0, m_raw()};
      LVL: return {20'h0, h1};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_msk = '0; m_typ = '0; m_pol = '0; m_pend = '0;
      h0 = '0; h1 = '0; h2 = '0; m_irq = 0;
    end else begin
      logic [11:0] a_s, a_d, edg, eoi;
      a_s = ~(h1 ^ m_pol);
      a_d = ~(h2 ^ m_pol);
      edg = a_s & ~a_d & m_en & m_typ;
      eoi = (wr && addr == 12'(EOI)) ? wdata[11:0] : 12'h0;
      m_irq = |(m_raw() & ~m_msk);
      m_pend = (m_pend & ~eoi & m_en & m_typ) | edg;
      if (wr) begin
        case (int'(addr))
          EN:  m_en  = wdata[11:0];
          MSK: m_msk = wdata[11:0];
          TYP: m_typ = wdata[11:0];
          POL: m_pol = wdata[11:0];
          default: ;
        endcase
      end
      h2 = h1; h1 = h0; h0 = line;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string rd_tag(int a);
    case (a)
      LVL: return "R2 level read";
      RAW: return "R4 raw read";
      MST: return "R7 masked read";
      default: return "R9 register read";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R8 irq_o vs model", {31'h0, irq}, {31'h0, m_irq});
      check(rd_tag(int'(addr)), rdata, m_read(int'(addr)));
    end
  end

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = 12'(a); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    @(negedge clk); addr = 12'(a);
    @(posedge clk); #1;
    check(tag, rdata, exp);
  endtask

  task automatic irq_chk(bit exp, string tag);
    check(tag, {31'h0, irq}, {31'h0, exp});
  endtask

  task automatic set_lines(logic [11:0] v, int wait_cyc);
    @(negedge clk); line = v;
    repeat (wait_cyc) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(EN,  0, "R1 enable after reset");
    rd_chk(MSK, 0, "R1 mask after reset");
    rd_chk(RAW, 0, "R1 raw after reset");
    irq_chk(0, "R1 irq after reset");

    // R2 synchronized levels
    set_lines(12'h0A5, 3);
    rd_chk(LVL, 32'h0A5, "R2 level port");
    wr_reg(LVL, 32'hFFFF_FFFF);
    rd_chk(LVL, 32'h0A5, "R9 write to level port ignored");
    wr_reg(RAW, 32'hFFF);
    rd_chk(RAW, 0, "R9 write to raw ignored");
    rd_chk('h900, 0, "R9 unmapped reads zero");

    // R9 readback
    wr_reg(EN, 32'hFFFF_FFFF);
    rd_chk(EN, 32'h0000_0FFF, "R9 enable readback upper zero");
    wr_reg(MSK, 32'hABC);
    rd_chk(MSK, 32'hABC, "R9 mask readback");
    wr_reg(POL, 32'h123);
    rd_chk(POL, 32'h123, "R9 polarity readback");
    wr_reg(EOI, 32'hFFF);
    rd_chk(EOI, 0, "R6 eoi reads zero");
    wr_reg(EN, 0); wr_reg(MSK, 0);

    // R4 level mode: bit0 high active-high, bit1 low active-low
    wr_reg(POL, 32'h001);
    wr_reg(EN, 32'h003);
    rd_chk(RAW, 32'h003, "R4 level polarity");
    irq_chk(1, "R8 irq on level");
    wr_reg(MSK, 32'h001);
    rd_chk(RAW, 32'h003, "R7 raw unaffected by mask");
    rd_chk(MST, 32'h002, "R7 masked status");
    wr_reg(MSK, 32'h003);
    rd_chk(MST, 0, "R7 all masked");
    irq_chk(0, "R7 irq blocked by mask");
    wr_reg(MSK, 0);
    wr_reg(EOI, 32'h003);
    rd_chk(RAW, 32'h003, "R6 level survives eoi");

    // R3 enable removes lines
    wr_reg(EN, 32'h002);
    rd_chk(RAW, 32'h002, "R3 line disabled");
    wr_reg(EN, 0);
    rd_chk(RAW, 0, "R3 all disabled raw");
    rd_chk(MST, 0, "R3 all disabled masked");
    irq_chk(0, "R3 irq low when disabled");

    // R5 edge mode, rising on bit4
    wr_reg(POL, 32'h010); wr_reg(TYP, 32'h010); wr_reg(EN, 32'h010);
    set_lines(12'h0B5, 1);
    set_lines(12'h0A5, 6);
    rd_chk(RAW, 32'h010, "R5 rising edge latched");
    irq_chk(1, "R8 irq on edge");
    wr_reg(EOI, 32'h000);
    rd_chk(RAW, 32'h010, "R6 eoi zero bits keep event");
    wr_reg(EOI, 32'h010);
    rd_chk(RAW, 0, "R6 eoi clears event");

    // R5 falling edge under active-low
    wr_reg(POL, 0);
    repeat (3) @(negedge clk);
    rd_chk(RAW, 0, "R5 polarity change makes no event");
    set_lines(12'h0B5, 4);
    rd_chk(RAW, 0, "R5 inactive-going transition ignored");
    set_lines(12'h0A5, 4);
    rd_chk(RAW, 32'h010, "R5 falling edge latched");

    // R10 enable and type drop pending events
    wr_reg(EN, 0); wr_reg(EN, 32'h010);
    rd_chk(RAW, 0, "R10 enable toggle drops event");
    set_lines(12'h0B5, 3);
    set_lines(12'h0A5, 4);
    rd_chk(RAW, 32'h010, "R5 second falling edge");
    wr_reg(POL, 32'h010);
    rd_chk(RAW, 32'h010, "R5 event held across polarity change");
    wr_reg(TYP, 0); wr_reg(TYP, 32'h010);
    rd_chk(RAW, 0, "R10 type toggle drops event");
    wr_reg(EN, 0); wr_reg(TYP, 0); wr_reg(POL, 0);

    // pseudo-random phase, compared every cycle
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      @(negedge clk);
      if (lfsr[3:0] < 4'd5) begin
        int sel;
        sel = int'(lfsr[6:4]) % 5;
        wr = 1'b1;
        addr = 12'(sel == 0 ? EN : sel == 1 ? MSK : sel == 2 ? TYP : sel == 3 ? POL : EOI);
        wdata = {lfsr[15:0], lfsr[31:16]};
      end else begin
        int rs;
        rs = int'(lfsr[10:8]);
        wr = 1'b0;
        addr = 12'(rs == 0 ? EN : rs == 1 ? MSK : rs == 2 ? TYP : rs == 3 ? POL :
                   rs == 4 ? MST : rs == 5 ? RAW : rs == 6 ? LVL : EOI);
        if (lfsr[11]) line = lfsr[27:16];
      end
    end
    @(negedge clk); wr = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule